// File: doc/BRIEF.md
# Four-Port Shared FIFO Host Access Port

This block gives one synchronous 32-bit host bus access to eight packet FIFOs: a receive FIFO and a transmit FIFO for each of four ports. A 2-bit port select picks the target. Separate active-low enables qualify the receive and the transmit side. A receive read takes the head double word, with its end-of-packet bit, from the selected receive FIFO. A transmit write pushes the host word and its end-of-packet bit into the selected transmit FIFO. Active-low byte enables mark the valid lanes in both directions.

A single active-high handshake output, `dvalid_o`, shows in the same cycle whether the transfer was taken. The per-port receive and transmit threshold flags are passed to the host only while the matching interface enable is low. At all other times their output enables are low, which stands in for tristate drivers.

The same port select also addresses three host commands: clear a transmit retry condition, clear a receive discard condition, and abort a receive packet. Each command turns into a one-cycle pulse to the selected port.

Top module: `fifo_host_port`

## Requirements
- R1: When `rx_if_n_i` and `rx_rd_n_i` are both low and the selected receive FIFO is not empty, only `rxf_pop_o[port_sel_i]` is high in that cycle, `dvalid_o` is high, and `rdata_o` carries bits 31:0 of that port's head word.
- R2: When `tx_if_n_i` and `tx_wr_n_i` are both low and no read is active, only `txf_push_o[port_sel_i]` is high if that FIFO is not full. `txf_data_o` is `{weop_i, wdata_i}`.
- R3: Byte lane k (bits 8k+7:8k) is enabled when `be_n_i[k]` is low. Disabled lanes read as zero on `rdata_o` and on `txf_data_o[31:0]`. `txf_be_o` is the bitwise inverse of `be_n_i`.
- R4: When a read and a write are both requested in one cycle, the read wins. No push occurs, even if the read itself is dropped.
- R5: A read from an empty receive FIFO pops nothing, holds `dvalid_o` low and drives `rdata_o` and `reop_o` to zero.
- R6: A write to a full transmit FIFO pushes nothing and holds `dvalid_o` low.
- R7: When neither enable pair is fully low, `dvalid_o` is low and nothing is popped or pushed.
- R8: `tx_rdy_oe_o` is all ones while `tx_if_n_i` is low, and all zeros otherwise. `tx_rdy_o` follows `tx_rdy_i` when enabled and is zero otherwise.
- R9: `rx_rdy_oe_o` and `rx_rdy_o` behave the same way, under the control of `rx_if_n_i` and `rx_rdy_i`.
- R10: A command strobe sampled high at a clock edge, after being low at the previous edge, drives a one-hot pulse on the matching command output at bit `port_sel_i` for exactly one cycle after that edge. A strobe held high gives one pulse. Commands are independent of each other.
- R11: While `rst_ni` is low, all command outputs are zero.
- R12: On an accepted read, `reop_o` equals bit 32 of the selected head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_if_n_i | input | 1 | Receive interface enable, active low |
| rx_rd_n_i | input | 1 | Receive read enable, active low |
| tx_if_n_i | input | 1 | Transmit interface enable, active low |
| tx_wr_n_i | input | 1 | Transmit write enable, active low |
| port_sel_i | input | 2 | Target port |
| be_n_i | input | 4 | Byte enables, active low |
| wdata_i | input | 32 | Host write data |
| weop_i | input | 1 | Last double word of a transmit packet |
| rdata_o | output | 32 | Host read data |
| reop_o | output | 1 | Last double word of a receive packet |
| dvalid_o | output | 1 | Transfer accepted |
| clr_retry_stb_i | input | 1 | Clear transmit retry command strobe |
| clr_disc_stb_i | input | 1 | Clear receive discard command strobe |
| rx_abort_stb_i | input | 1 | Abort receive packet command strobe |
| clr_retry_o | output | 4 | Per-port clear retry pulse |
| clr_disc_o | output | 4 | Per-port clear discard pulse |
| rx_abort_o | output | 4 | Per-port receive abort pulse |
| rxf_data_i | input | 132 | Head words of the four receive FIFOs, 33 bits each, port 0 lowest |
| rxf_empty_i | input | 4 | Receive FIFO empty |
| rxf_pop_o | output | 4 | Receive FIFO pop |
| txf_full_i | input | 4 | Transmit FIFO full |
| txf_push_o | output | 4 | Transmit FIFO push |
| txf_data_o | output | 33 | Transmit write word, end-of-packet at bit 32 |
| txf_be_o | output | 4 | Transmit byte mask, active high |
| tx_rdy_i | input | 4 | Transmit threshold flags from FIFOs |
| rx_rdy_i | input | 4 | Receive threshold flags from FIFOs |
| tx_rdy_o | output | 4 | Gated transmit flags |
| tx_rdy_oe_o | output | 4 | Transmit flag output enables |
| rx_rdy_o | output | 4 | Gated receive flags |
| rx_rdy_oe_o | output | 4 | Receive flag output enables |

## Verification
The bench targets the collision of a read and a write in one cycle, both when the read is taken and when it is dropped on an empty FIFO. A design that let the write through would push a word the host believes was refused. It checks drops on a full or empty FIFO where a neighbouring port is in the opposite state, which catches any design that tests the wrong port's status. It masks alternating byte lanes so that a reversed lane order shows up as wrong data. It also holds a command strobe high over several cycles: a level-sensitive design would repeat the clear and hit the port again.

// File: rtl/fhp_pkg.sv
package fhp_pkg;
  localparam int NPORT_DEF = 4;
  localparam int DW_DEF    = 32;
  localparam int NCMD      = 3;

  typedef enum logic [1:0] {
    CMD_CLR_RETRY = 2'd0,
    CMD_CLR_DISC  = 2'd1,
    CMD_RX_ABORT  = 2'd2
  } cmd_e;
endpackage

// File: rtl/fhp_xfer.sv
module fhp_xfer #(
  parameter int NPORT = 4,
  parameter int DW    = 32,
  localparam int PSW  = $clog2(NPORT),
  localparam int NB   = DW / 8,
  localparam int WW   = DW + 1
) (
  input  logic             rx_if_n_i,
  input  logic             rx_rd_n_i,
  input  logic             tx_if_n_i,
  input  logic             tx_wr_n_i,
  input  logic [PSW-1:0]   sel_i,
  input  logic [NB-1:0]    be_n_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             weop_i,
  input  logic [NPORT*WW-1:0] rxf_data_i,
  input  logic [NPORT-1:0] rxf_empty_i,
  input  logic [NPORT-1:0] txf_full_i,
  output logic [NPORT-1:0] rxf_pop_o,
  output logic [NPORT-1:0] txf_push_o,
  output logic [WW-1:0]    txf_data_o,
  output logic [NB-1:0]    txf_be_o,
  output logic [DW-1:0]    rdata_o,
  output logic             reop_o,
  output logic             dvalid_o
);
  logic [DW-1:0] lane_m;
  logic [WW-1:0] head;
  logic rd_req, wr_req, rd_ok, wr_ok;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_m[b*8 +: 8] = {8{~be_n_i[b]}};
  end

  assign head   = rxf_data_i[sel_i*WW +: WW];
  assign rd_req = ~rx_if_n_i & ~rx_rd_n_i;
  // read side wins a collision
  assign wr_req = ~tx_if_n_i & ~tx_wr_n_i & ~rd_req;
  assign rd_ok  = rd_req & ~rxf_empty_i[sel_i];
  assign wr_ok  = wr_req & ~txf_full_i[sel_i];

  always_comb begin
    rxf_pop_o  = '0;
    txf_push_o = '0;
    rxf_pop_o[sel_i]  = rd_ok;
    txf_push_o[sel_i] = wr_ok;
  end

  assign rdata_o    = rd_ok ? (head[DW-1:0] & lane_m) : '0;
  assign reop_o     = rd_ok & head[DW];
  assign dvalid_o   = rd_ok | wr_ok;
  assign txf_data_o = {weop_i, wdata_i & lane_m};
  assign txf_be_o   = ~be_n_i;
endmodule

// File: rtl/fhp_flag_gate.sv
module fhp_flag_gate #(
  parameter int NPORT = 4
) (
  input  logic             if_n_i,
  input  logic [NPORT-1:0] rdy_i,
  output logic [NPORT-1:0] rdy_o,
  output logic [NPORT-1:0] oe_o
);
  assign oe_o  = {NPORT{~if_n_i}};
  assign rdy_o = rdy_i & oe_o;
endmodule

// File: rtl/fhp_cmd.sv
module fhp_cmd #(
  parameter int NPORT = 4,
  parameter int NCMD  = 3,
  localparam int PSW  = $clog2(NPORT)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PSW-1:0]        sel_i,
  input  logic [NCMD-1:0]       stb_i,
  output logic [NCMD*NPORT-1:0] pulse_o
);
  logic [NPORT-1:0] sel_oh;

  always_comb begin
    sel_oh = '0;
    sel_oh[sel_i] = 1'b1;
  end

  for (genvar c = 0; c < NCMD; c++) begin : g_cmd
    logic             stb_q;
    logic [NPORT-1:0] pulse_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stb_q   <= 1'b0;
        pulse_q <= '0;
      end else begin
        stb_q   <= stb_i[c];
        pulse_q <= (stb_i[c] & ~stb_q) ? sel_oh : '0;
      end
    end
    assign pulse_o[c*NPORT +: NPORT] = pulse_q;
  end
endmodule

// File: rtl/fifo_host_port.sv
module fifo_host_port
  import fhp_pkg::*;
#(
  parameter int NPORT = NPORT_DEF,
  parameter int DW    = DW_DEF,
  localparam int PSW  = $clog2(NPORT),
  localparam int NB   = DW / 8,
  localparam int WW   = DW + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_if_n_i,
  input  logic                rx_rd_n_i,
  input  logic                tx_if_n_i,
  input  logic                tx_wr_n_i,
  input  logic [PSW-1:0]      port_sel_i,
  input  logic [NB-1:0]       be_n_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                weop_i,
  output logic [DW-1:0]       rdata_o,
  output logic                reop_o,
  output logic                dvalid_o,
  input  logic                clr_retry_stb_i,
  input  logic                clr_disc_stb_i,
  input  logic                rx_abort_stb_i,
  output logic [NPORT-1:0]    clr_retry_o,
  output logic [NPORT-1:0]    clr_disc_o,
  output logic [NPORT-1:0]    rx_abort_o,
  input  logic [NPORT*WW-1:0] rxf_data_i,
  input  logic [NPORT-1:0]    rxf_empty_i,
  output logic [NPORT-1:0]    rxf_pop_o,
  input  logic [NPORT-1:0]    txf_full_i,
  output logic [NPORT-1:0]    txf_push_o,
  output logic [WW-1:0]       txf_data_o,
  output logic [NB-1:0]       txf_be_o,
  input  logic [NPORT-1:0]    tx_rdy_i,
  input  logic [NPORT-1:0]    rx_rdy_i,
  output logic [NPORT-1:0]    tx_rdy_o,
  output logic [NPORT-1:0]    tx_rdy_oe_o,
  output logic [NPORT-1:0]    rx_rdy_o,
  output logic [NPORT-1:0]    rx_rdy_oe_o
);
  logic [NCMD-1:0]       stb;
  logic [NCMD*NPORT-1:0] pulse;

  fhp_xfer #(.NPORT(NPORT), .DW(DW)) u_xfer (
    .rx_if_n_i (rx_if_n_i),
    .rx_rd_n_i (rx_rd_n_i),
    .tx_if_n_i (tx_if_n_i),
    .tx_wr_n_i (tx_wr_n_i),
    .sel_i     (port_sel_i),
    .be_n_i    (be_n_i),
    .wdata_i   (wdata_i),
    .weop_i    (weop_i),
    .rxf_data_i(rxf_data_i),
    .rxf_empty_i(rxf_empty_i),
    .txf_full_i(txf_full_i),
    .rxf_pop_o (rxf_pop_o),
    .txf_push_o(txf_push_o),
    .txf_data_o(txf_data_o),
    .txf_be_o  (txf_be_o),
    .rdata_o   (rdata_o),
    .reop_o    (reop_o),
    .dvalid_o  (dvalid_o)
  );

  fhp_flag_gate #(.NPORT(NPORT)) u_tx_gate (
    .if_n_i(tx_if_n_i), .rdy_i(tx_rdy_i), .rdy_o(tx_rdy_o), .oe_o(tx_rdy_oe_o)
  );

  fhp_flag_gate #(.NPORT(NPORT)) u_rx_gate (
    .if_n_i(rx_if_n_i), .rdy_i(rx_rdy_i), .rdy_o(rx_rdy_o), .oe_o(rx_rdy_oe_o)
  );

  always_comb begin
    stb = '0;
    stb[CMD_CLR_RETRY] = clr_retry_stb_i;
    stb[CMD_CLR_DISC]  = clr_disc_stb_i;
    stb[CMD_RX_ABORT]  = rx_abort_stb_i;
  end

  fhp_cmd #(.NPORT(NPORT), .NCMD(NCMD)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (port_sel_i),
    .stb_i  (stb),
    .pulse_o(pulse)
  );

  assign clr_retry_o = pulse[int'(CMD_CLR_RETRY)*NPORT +: NPORT];
  assign clr_disc_o  = pulse[int'(CMD_CLR_DISC)*NPORT +: NPORT];
  assign rx_abort_o  = pulse[int'(CMD_RX_ABORT)*NPORT +: NPORT];
endmodule

// File: rtl/fhp_checks.sv
module fhp_checks #(
  parameter int NPORT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_if_n_i,
  input logic             rx_rd_n_i,
  input logic             tx_if_n_i,
  input logic             tx_wr_n_i,
  input logic             dvalid_o,
  input logic [NPORT-1:0] rxf_empty_i,
  input logic [NPORT-1:0] rxf_pop_o,
  input logic [NPORT-1:0] txf_full_i,
  input logic [NPORT-1:0] txf_push_o,
  input logic [NPORT-1:0] tx_rdy_o,
  input logic [NPORT-1:0] tx_rdy_oe_o,
  input logic [NPORT-1:0] rx_rdy_o,
  input logic [NPORT-1:0] rx_rdy_oe_o,
  input logic [NPORT-1:0] clr_retry_o,
  input logic [NPORT-1:0] clr_disc_o,
  input logic [NPORT-1:0] rx_abort_o
);
  p_pop_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rxf_pop_o));
  p_push_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(txf_push_o));
  p_rd_priority_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_if_n_i && !rx_rd_n_i) |-> (txf_push_o == '0));
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxf_pop_o & rxf_empty_i) == '0);
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txf_push_o & txf_full_i) == '0);
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_if_n_i || rx_rd_n_i) && (tx_if_n_i || tx_wr_n_i)) |-> !dvalid_o);
  p_tx_flag_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_if_n_i |-> (tx_rdy_oe_o == '0 && tx_rdy_o == '0));
  p_rx_flag_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_if_n_i |-> (rx_rdy_oe_o == '0 && rx_rdy_o == '0));
  p_cmd_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_retry_o) && $onehot0(clr_disc_o) && $onehot0(rx_abort_o));
  p_retry_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_retry_o) |=> (clr_retry_o == '0));
  p_abort_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_abort_o) |=> (rx_abort_o == '0));
endmodule

bind fifo_host_port fhp_checks #(.NPORT(NPORT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rx_if_n_i(rx_if_n_i), .rx_rd_n_i(rx_rd_n_i),
  .tx_if_n_i(tx_if_n_i), .tx_wr_n_i(tx_wr_n_i),
  .dvalid_o(dvalid_o),
  .rxf_empty_i(rxf_empty_i), .rxf_pop_o(rxf_pop_o),
  .txf_full_i(txf_full_i), .txf_push_o(txf_push_o),
  .tx_rdy_o(tx_rdy_o), .tx_rdy_oe_o(tx_rdy_oe_o),
  .rx_rdy_o(rx_rdy_o), .rx_rdy_oe_o(rx_rdy_oe_o),
  .clr_retry_o(clr_retry_o), .clr_disc_o(clr_disc_o), .rx_abort_o(rx_abort_o)
);

// File: tb/fifo_host_port_test.sv
module fifo_host_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic rx_if_n = 1, rx_rd_n = 1, tx_if_n = 1, tx_wr_n = 1;
  logic [1:0] sel = '0;
  logic [3:0] be_n = '0;
  logic [31:0] wdata = 32'hCAFEF00D;
  logic weop = 1'b1;
  logic [31:0] rdata;
  logic reop, dvalid;
  logic s_retry = 0, s_disc = 0, s_abort = 0;
  logic [3:0] o_retry, o_disc, o_abort;
  logic [131:0] rxf_data;
  logic [3:0] rxf_empty = '0, rxf_pop, txf_full = '0, txf_push;
  logic [32:0] txf_data;
  logic [3:0] txf_be;
  logic [3:0] tx_rdy = 4'b1010, rx_rdy = 4'b0110;
  logic [3:0] tx_rdy_o, tx_oe, rx_rdy_o, rx_oe;

  int n_run = 0, n_fail = 0;

  function automatic logic [32:0] head_of(int p);
    logic [31:0] d = 32'h11223344 * (p + 1);
    return {1'(p & 1), d};
  endfunction

  function automatic logic [31:0] lanes(logic [3:0] bn);
    return {{8{~bn[3]}}, {8{~bn[2]}}, {8{~bn[1]}}, {8{~bn[0]}}};
  endfunction

  always_comb
    for (int p = 0; p < 4; p++) rxf_data[p*33 +: 33] = head_of(p);

  fifo_host_port uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_if_n_i(rx_if_n), .rx_rd_n_i(rx_rd_n), .tx_if_n_i(tx_if_n), .tx_wr_n_i(tx_wr_n),
    .port_sel_i(sel), .be_n_i(be_n), .wdata_i(wdata), .weop_i(weop),
    .rdata_o(rdata), .reop_o(reop), .dvalid_o(dvalid),
    .clr_retry_stb_i(s_retry), .clr_disc_stb_i(s_disc), .rx_abort_stb_i(s_abort),
    .clr_retry_o(o_retry), .clr_disc_o(o_disc), .rx_abort_o(o_abort),
    .rxf_data_i(rxf_data), .rxf_empty_i(rxf_empty), .rxf_pop_o(rxf_pop),
    .txf_full_i(txf_full), .txf_push_o(txf_push), .txf_data_o(txf_data), .txf_be_o(txf_be),
    .tx_rdy_i(tx_rdy), .rx_rdy_i(rx_rdy),
    .tx_rdy_o(tx_rdy_o), .tx_rdy_oe_o(tx_oe), .rx_rdy_o(rx_rdy_o), .rx_rdy_oe_o(rx_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {rif,rrd,tif,twr, sel, be_n, empty, full | pop, push, dvalid}
  typedef logic [26:0] vec_t;
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    {4'b0011, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 1'b1}, // R1 read p0
    {4'b0011, 2'd2, 4'b1010, 4'b0000, 4'b0000, 4'b0100, 4'b0000, 1'b1}, // R3 read masked
    {4'b1100, 2'd1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b1}, // R2 write p1
    {4'b1100, 2'd3, 4'b0111, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 1'b1}, // R3 write masked
    {4'b0000, 2'd1, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 1'b1}, // R4 collision
    {4'b0011, 2'd3, 4'b0000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 1'b0}, // R5 empty read
    {4'b0011, 2'd1, 4'b0000, 4'b1000, 4'b0000, 4'b0010, 4'b0000, 1'b1}, // R5 neighbour empty
    {4'b1100, 2'd0, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 1'b0}, // R6 full write
    {4'b0111, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0}, // R7 rif only
    {4'b1101, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0}, // R7 tif only
    {4'b1011, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0}, // R7 rrd only
    {4'b0000, 2'd2, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0}  // R4 collision, read dropped
  };

  function automatic string vreq(int i);
    case (i)
      0: return "R1"; 1, 3: return "R3"; 2: return "R2";
      4, 11: return "R4"; 5, 6: return "R5"; 7: return "R6";
      default: return "R7";
    endcase
  endfunction

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    s_retry = 1;
    #1;
    chk(o_retry == 0 && o_disc == 0 && o_abort == 0, "R11 reset", {o_retry, o_disc, o_abort}, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(o_retry == 0, "R11 strobe in reset", o_retry, 0);
    @(negedge clk); s_retry = 0; rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      {rx_if_n, rx_rd_n, tx_if_n, tx_wr_n} = v[26:23];
      sel = v[22:21]; be_n = v[20:17]; rxf_empty = v[16:13]; txf_full = v[12:9];
      #1;
      begin
        logic [31:0] er = (v[8:5] != 0) ? (head_of(int'(sel)) & {1'b0, lanes(be_n)}) : 32'h0;
        logic        ee = (v[8:5] != 0) && sel[0];
        chk(rxf_pop == v[8:5], vreq(i), rxf_pop, v[8:5]);
        chk(txf_push == v[4:1], vreq(i), txf_push, v[4:1]);
        chk(dvalid == v[0], vreq(i), dvalid, v[0]);
        chk(rdata == er, vreq(i), rdata, er);
        chk(reop == ee, "R12", reop, ee);
        chk(txf_data == {1'b1, wdata & lanes(be_n)}, "R3 txdata", txf_data, {1'b1, wdata & lanes(be_n)});
        chk(txf_be == ~be_n, "R3 txbe", txf_be, ~be_n);
      end
      @(negedge clk);
    end

    // flag gating
    rx_if_n = 1; tx_if_n = 1; rx_rd_n = 1; tx_wr_n = 1; rxf_empty = 0; txf_full = 0; be_n = 0;
    #1;
    chk(tx_oe == 0 && tx_rdy_o == 0, "R8 off", {tx_oe, tx_rdy_o}, 0);
    chk(rx_oe == 0 && rx_rdy_o == 0, "R9 off", {rx_oe, rx_rdy_o}, 0);
    tx_if_n = 0; #1;
    chk(tx_oe == 4'hF && tx_rdy_o == 4'b1010, "R8 on", {tx_oe, tx_rdy_o}, 8'hFA);
    chk(rx_oe == 0, "R9 tx only", rx_oe, 0);
    tx_if_n = 1; rx_if_n = 0; #1;
    chk(rx_oe == 4'hF && rx_rdy_o == 4'b0110, "R9 on", {rx_oe, rx_rdy_o}, 8'hF6);
    chk(tx_oe == 0, "R8 rx only", tx_oe, 0);
    rx_if_n = 1;

    // command pulses, strobe held for three edges
    @(negedge clk); sel = 2; s_retry = 1;
    @(posedge clk); #1;
    chk(o_retry == 4'b0100, "R10 retry pulse", o_retry, 4'b0100);
    chk(o_disc == 0 && o_abort == 0, "R10 others quiet", {o_disc, o_abort}, 0);
    @(posedge clk); #1;
    chk(o_retry == 0, "R10 held strobe", o_retry, 0);
    @(posedge clk); #1;
    chk(o_retry == 0, "R10 held strobe", o_retry, 0);
    @(negedge clk); s_retry = 0; sel = 1; s_abort = 1; s_disc = 1;
    @(posedge clk); #1;
    chk(o_abort == 4'b0010, "R10 abort pulse", o_abort, 4'b0010);
    chk(o_disc == 4'b0010, "R10 discard pulse", o_disc, 4'b0010);
    chk(o_retry == 0, "R10 retry quiet", o_retry, 0);
    @(negedge clk); s_abort = 0; s_disc = 0; sel = 3;
    @(posedge clk); #1;
    chk(o_abort == 0 && o_disc == 0, "R10 pulse ends", {o_abort, o_disc}, 0);
    @(negedge clk); s_disc = 1;
    @(posedge clk); #1;
    chk(o_disc == 4'b1000, "R10 rearmed", o_disc, 4'b1000);
    rst_n = 0; #1;
    chk(o_disc == 0, "R11 async reset", o_disc, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule